// File: doc/BRIEF.md
# In-System Serial Programming Target

This block is the target end of a four-wire serial programming port. While the active-low `prog_rst_n` pin is held low, a host clocks 4-byte instructions in on `mosi` with `sck` and collects one reply byte per instruction byte on `miso`. The block samples `sck` and `mosi` with its own faster system clock and finds the serial clock edges from those samples. It holds two behavioural non-volatile arrays of its own: a program array of 16-bit words and a byte-wide EEPROM array. The host can read and write both arrays and can erase both of them at once.

The host must send a programming-enable instruction before any other instruction takes effect. The block echoes the enable key back one byte later, so the host can tell whether its byte framing matches the target's. When framing is lost, the host parks `sck` low and pulses `prog_rst_n` high. This clears the framing and the enable state, and the host then starts again. Each write or erase starts a busy period. Any instruction that completes during the busy period is dropped.

The port is a plain bit-serial link. The host paces every transfer with `sck` and the block has no way to hold it off, so the port has no valid/ready handshake and no back-pressure.

Top module: `spt_target`

## Requirements
- R1: While `prog_rst_n` is high, the bit and byte framing, the enable state and the busy state are held cleared and `miso` is driven 0.
- R2: Instructions are exactly 4 bytes long and are shifted most significant bit first. During byte 0 `miso` returns 0x00. During bytes 1 and 2 `miso` returns the byte received just before. During byte 3 `miso` returns either read data or received byte 2.
- R3: Programming enable is 0xAC 0x53 xx xx. The 0x53 key comes back on `miso` during byte 2 of the same instruction. The enable state is set when byte 3 completes.
- R4: Until enable has been accepted, every other instruction has no effect: a write leaves the array unchanged, and a read returns received byte 2 in byte 3.
- R5: `mosi` is taken at each rising edge of `sck`, and `miso` changes only after a falling edge of `sck`. The low and high phases of `sck` must each last at least 3 system clocks.
- R6: 0x20 or 0x28 reads the low or high byte of the program word. The 11-bit word address is {byte1[2:0], byte2}, and the data is returned in byte 3.
- R7: 0x40 or 0x48 writes byte 3 into the low or high byte of the program word at the same address, and leaves the other half of the word unchanged.
- R8: 0xA0 reads and 0xC0 writes the EEPROM byte at address byte2. The EEPROM and the program array are separate address spaces, so a write to one never changes the other.
- R9: Chip erase is 0xAC 0x80 xx xx. It sets every program word to 0xFFFF and every EEPROM byte to 0xFF. The erase keeps the block busy for 2^max(PROG_AW,EE_AW) system clocks.
- R10: A write starts a busy period of BUSY_CYC system clocks. An instruction whose final byte completes while the block is busy is discarded. A read whose address byte completes while the block is busy returns received byte 2 in byte 3.
- R11: A high pulse on `prog_rst_n` with `sck` low resynchronises the framing and clears the enable state. The host must then send programming enable again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| prog_rst_n | input | 1 | Low selects programming mode; high clears the port |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply data to the host |

## Verification
A wrong bit or byte count inside the block shows up on `miso` within the same instruction: the echoed 0x53 moves to the wrong byte or arrives shifted. A wrong enable or busy state shows up one instruction later: a read returns its own address byte where stored data was expected, or a write that should have landed is missing at the next read-back. A bad erase sweep leaves locations that do not read 0xFF the first time they are read after the busy period ends.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [7:0] {
    OP_ACCESS = 8'hAC,
    OP_RD_PLO = 8'h20,
    OP_RD_PHI = 8'h28,
    OP_WR_PLO = 8'h40,
    OP_WR_PHI = 8'h48,
    OP_RD_EE  = 8'hA0,
    OP_WR_EE  = 8'hC0
  } spt_op_e;

  localparam logic [7:0] ENA_KEY   = 8'h53;
  localparam logic [7:0] ERASE_KEY = 8'h80;
  localparam int unsigned FRAME_BYTES = 4;
endpackage

// File: rtl/spt_sck_edge.sv
module spt_sck_edge (
  input  logic clk,
  input  logic clr,
  input  logic sck,
  input  logic mosi,
  output logic rise,
  output logic fall,
  output logic mosi_s
);
  logic [2:0] sck_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign rise   = sck_q[1] & ~sck_q[2];
  assign fall   = ~sck_q[1] & sck_q[2];
  assign mosi_s = mosi_q[1];
endmodule

// File: rtl/spt_frame.sv
module spt_frame import spt_pkg::*; (
  input  logic       clk,
  input  logic       clr,
  input  logic       rise,
  input  logic       fall,
  input  logic       mosi_s,
  input  logic [7:0] load_val,
  output logic       byte_done,
  output logic [1:0] byte_idx,
  output logic [7:0] rx_byte,
  output logic       miso
);
  localparam logic [1:0] LAST_IDX = 2'(FRAME_BYTES - 1);

  logic [2:0] bit_cnt;
  logic [6:0] sr;
  logic [7:0] tx_sr;
  logic       miso_q;

  assign rx_byte   = {sr, mosi_s};
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign miso      = miso_q;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      bit_cnt  <= '0;
      sr       <= '0;
      byte_idx <= '0;
      tx_sr    <= '0;
      miso_q   <= 1'b0;
    end else if (rise) begin
      sr      <= {sr[5:0], mosi_s};
      bit_cnt <= bit_cnt + 3'd1;
      if (byte_done) begin
        byte_idx <= (byte_idx == LAST_IDX) ? 2'd0 : byte_idx + 2'd1;
        tx_sr    <= load_val;
      end
    end else if (fall) begin
      miso_q <= tx_sr[7];
      tx_sr  <= {tx_sr[6:0], 1'b0};
    end
  end

  AST_BITCNT_ON_RISE: assert property (@(posedge clk) disable iff (clr)
    !rise |=> $stable(bit_cnt)); // R5
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (clr)
    !fall |=> $stable(miso_q)); // R5
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (clr)
    (byte_done && byte_idx == LAST_IDX) |=> (byte_idx == 2'd0)); // R2
endmodule

// File: rtl/spt_exec.sv
module spt_exec import spt_pkg::*; #(
  parameter int unsigned PROG_AW  = 11,
  parameter int unsigned EE_AW    = 8,
  parameter int unsigned BUSY_CYC = 600
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       byte_done,
  input  logic [1:0] byte_idx,
  input  logic [7:0] rx_byte,
  output logic [7:0] load_val
);
  localparam int unsigned PROG_DEPTH = 1 << PROG_AW;
  localparam int unsigned EE_DEPTH   = 1 << EE_AW;
  localparam int unsigned SWEEP_AW   = (PROG_AW > EE_AW) ? PROG_AW : EE_AW;
  localparam int unsigned ERASE_CYC  = 1 << SWEEP_AW;
  localparam int unsigned CNT_MAX    = (BUSY_CYC > ERASE_CYC) ? BUSY_CYC : ERASE_CYC;
  localparam int unsigned CW         = $clog2(CNT_MAX + 1);

  logic [15:0] prog_mem [PROG_DEPTH];
  logic [7:0]  ee_mem   [EE_DEPTH];

  logic [7:0]          b0, b1, b2;
  logic                enabled, erase_act, busy;
  logic [CW-1:0]       busy_cnt;
  logic [SWEEP_AW-1:0] sweep;
  logic [PROG_AW-1:0]  rd_pa, wr_pa, sweep_pa;
  logic [EE_AW-1:0]    rd_ea, wr_ea;
  logic                is_read, rd_ok;
  logic [7:0]          rd_data;
  logic                exec_go, cmd_ok, ena_go, erase_go, wr_plo, wr_phi, wr_ee;

  assign busy     = (busy_cnt != '0);
  assign rd_pa    = {b1[PROG_AW-9:0], rx_byte};
  assign wr_pa    = {b1[PROG_AW-9:0], b2};
  assign rd_ea    = rx_byte[EE_AW-1:0];
  assign wr_ea    = b2[EE_AW-1:0];
  assign sweep_pa = sweep[PROG_AW-1:0];

  always_comb begin
    is_read = 1'b1;
    rd_data = 8'h00;
    case (b0)
      OP_RD_PLO: rd_data = prog_mem[rd_pa][7:0];
      OP_RD_PHI: rd_data = prog_mem[rd_pa][15:8];
      OP_RD_EE:  rd_data = ee_mem[rd_ea];
      default:   is_read = 1'b0;
    endcase
    rd_ok = enabled && !busy && is_read;
    case (byte_idx)
      2'd3:    load_val = 8'h00;
      2'd2:    load_val = rd_ok ? rd_data : rx_byte;
      default: load_val = rx_byte;
    endcase
  end

  assign exec_go  = byte_done && (byte_idx == 2'd3);
  assign cmd_ok   = exec_go && enabled && !busy;
  assign ena_go   = exec_go && (b0 == OP_ACCESS) && (b1 == ENA_KEY);
  assign erase_go = cmd_ok && (b0 == OP_ACCESS) && (b1 == ERASE_KEY);
  assign wr_plo   = cmd_ok && (b0 == OP_WR_PLO);
  assign wr_phi   = cmd_ok && (b0 == OP_WR_PHI);
  assign wr_ee    = cmd_ok && (b0 == OP_WR_EE);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      b0 <= '0; b1 <= '0; b2 <= '0;
      enabled   <= 1'b0;
      busy_cnt  <= '0;
      erase_act <= 1'b0;
      sweep     <= '0;
    end else begin
      if (byte_done) begin
        case (byte_idx)
          2'd0:    b0 <= rx_byte;
          2'd1:    b1 <= rx_byte;
          2'd2:    b2 <= rx_byte;
          default: ;
        endcase
      end
      if (ena_go) enabled <= 1'b1;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (erase_act) begin
        sweep <= sweep + 1'b1;
        if (sweep == '1) erase_act <= 1'b0;
      end
      if (erase_go) begin
        busy_cnt  <= CW'(ERASE_CYC);
        erase_act <= 1'b1;
        sweep     <= '0;
      end else if (wr_plo || wr_phi || wr_ee) begin
        busy_cnt <= CW'(BUSY_CYC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erase_act) begin
      prog_mem[sweep_pa]          <= 16'hFFFF;
      ee_mem[sweep[EE_AW-1:0]]    <= 8'hFF;
    end else begin
      if (wr_plo) prog_mem[wr_pa][7:0]  <= rx_byte;
      if (wr_phi) prog_mem[wr_pa][15:8] <= rx_byte;
      if (wr_ee)  ee_mem[wr_ea]         <= rx_byte;
    end
  end

  AST_ENABLE_AT_FRAME_END: assert property (@(posedge clk) disable iff (clr)
    !(byte_done && byte_idx == 2'd3) |=> $stable(enabled)); // R4
  AST_WRITE_STARTS_BUSY: assert property (@(posedge clk) disable iff (clr)
    (wr_plo || wr_phi || wr_ee) |=> busy); // R10
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (clr)
    busy |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R10
  AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (clr)
    erase_act |=> (prog_mem[$past(sweep_pa)] == 16'hFFFF)); // R9
endmodule

// File: rtl/spt_target.sv
module spt_target #(
  parameter int unsigned PROG_AW  = 11,
  parameter int unsigned EE_AW    = 8,
  parameter int unsigned BUSY_CYC = 600
) (
  input  logic clk,
  input  logic prog_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic       rise, fall, mosi_s, byte_done;
  logic [1:0] byte_idx;
  logic [7:0] rx_byte, load_val;

  spt_sck_edge u_edge (
    .clk(clk), .clr(prog_rst_n), .sck(sck), .mosi(mosi),
    .rise(rise), .fall(fall), .mosi_s(mosi_s)
  );

  spt_frame u_frame (
    .clk(clk), .clr(prog_rst_n), .rise(rise), .fall(fall), .mosi_s(mosi_s),
    .load_val(load_val), .byte_done(byte_done), .byte_idx(byte_idx),
    .rx_byte(rx_byte), .miso(miso)
  );

  spt_exec #(.PROG_AW(PROG_AW), .EE_AW(EE_AW), .BUSY_CYC(BUSY_CYC)) u_exec (
    .clk(clk), .clr(prog_rst_n), .byte_done(byte_done), .byte_idx(byte_idx),
    .rx_byte(rx_byte), .load_val(load_val)
  );
endmodule

// File: tb/sim_spt_target.sv
module sim_spt_target;
  localparam int HALF = 6;
  localparam int BUSY = 600;

  logic clk = 1'b0;
  logic prog_rst_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic [15:0] pm [2048];
  logic [7:0]  em [256];

  always #5 clk = ~clk;

  spt_target #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .prog_rst_n(prog_rst_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] v, input int nb,
                            output logic [31:0] resp);
    resp = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = v[i];
      clocks(HALF);
      resp[i] = miso;
      sck = 1'b1;
      clocks(HALF);
      sck = 1'b0;
    end
    mosi = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] cmd, output logic [31:0] resp);
    shift_bits(cmd, 32, resp);
  endtask

  function automatic logic [31:0] exp_resp(input logic [31:0] cmd, input bit rd,
                                           input logic [7:0] d);
    return {8'h00, cmd[31:24], cmd[23:16], rd ? d : cmd[15:8]};
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] op, input logic [10:0] a,
                                     input logic [7:0] d);
    return {op, 5'b0, a[10:8], a[7:0], d};
  endfunction

  task automatic wr_op(input logic [31:0] cmd);
    logic [31:0] r;
    xfer(cmd, r);
    clocks(BUSY + 20);
  endtask

  task automatic rd_chk(input logic [31:0] cmd, input logic [7:0] d, input string tag);
    logic [31:0] r;
    xfer(cmd, r);
    chk(r == exp_resp(cmd, 1'b1, d), tag, r, exp_resp(cmd, 1'b1, d));
  endtask

  initial begin
    int ok_wd;
    ok_wd = 0;
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, c;
    void'($urandom(32'd1234));
    clocks(5);
    chk(miso == 1'b0, "R1 miso held low in reset", 32'(miso), 32'h0);
    prog_rst_n = 1'b0;
    clocks(10);

    // R4: read before enable only echoes
    c = mk(8'hA0, 11'h005, 8'h00);
    xfer(c, r);
    chk(r == exp_resp(c, 1'b0, 8'h00), "R4 read before enable", r, exp_resp(c, 1'b0, 8'h00));

    // R2 R3 R5: enable echo, MSB first, sampled on edges
    c = 32'hAC53_0000;
    xfer(c, r);
    chk(r[15:8] == 8'h53, "R3 enable key echo", 32'(r[15:8]), 32'h53);
    chk(r == 32'h00AC_5300, "R2 R5 frame echo layout", r, 32'h00AC_5300);

    // R9: chip erase
    xfer(32'hAC80_0000, r);
    clocks(2200);
    for (int k = 0; k < 4; k++) begin
      logic [10:0] a = 11'($urandom);
      rd_chk(mk(8'h20, a, 8'h00), 8'hFF, "R9 program low erased");
      rd_chk(mk(8'h28, a, 8'h00), 8'hFF, "R9 program high erased");
      rd_chk(mk(8'hA0, {3'b0, a[7:0]}, 8'h00), 8'hFF, "R9 eeprom erased");
    end
    for (int i = 0; i < 2048; i++) pm[i] = 16'hFFFF;
    for (int i = 0; i < 256; i++) em[i] = 8'hFF;

    // R6 R7: top program address, both halves
    wr_op(mk(8'h40, 11'h7FF, 8'h5A));
    rd_chk(mk(8'h28, 11'h7FF, 8'h00), 8'hFF, "R7 low write leaves high half");
    wr_op(mk(8'h48, 11'h7FF, 8'hA5));
    rd_chk(mk(8'h20, 11'h7FF, 8'h00), 8'h5A, "R6 read low byte at top");
    rd_chk(mk(8'h28, 11'h7FF, 8'h00), 8'hA5, "R6 read high byte at top");
    pm[11'h7FF] = 16'hA55A;

    // R8: EEPROM top address and separate space
    wr_op(mk(8'hC0, 11'h0FF, 8'h3C));
    rd_chk(mk(8'hA0, 11'h0FF, 8'h00), 8'h3C, "R8 eeprom top address");
    wr_op(mk(8'hC0, 11'h010, 8'h77));
    rd_chk(mk(8'h20, 11'h010, 8'h00), 8'hFF, "R8 eeprom write not in program space");
    em[8'hFF] = 8'h3C; em[8'h10] = 8'h77;

    // R10: second write inside busy window is discarded
    xfer(mk(8'hC0, 11'h020, 8'h33), r);
    xfer(mk(8'hC0, 11'h020, 8'h44), r);
    clocks(BUSY + 100);
    rd_chk(mk(8'hA0, 11'h020, 8'h00), 8'h33, "R10 write during busy discarded");
    em[8'h20] = 8'h33;
    xfer(mk(8'hC0, 11'h021, 8'h55), r);
    c = mk(8'hA0, 11'h021, 8'h00);
    xfer(c, r);
    chk(r == exp_resp(c, 1'b0, 8'h00), "R10 read during busy echoes", r, exp_resp(c, 1'b0, 8'h00));
    clocks(BUSY + 20);
    em[8'h21] = 8'h55;

    // R6 R7 R8: random traffic against model
    for (int k = 0; k < 30; k++) begin
      logic [10:0] a = 11'($urandom);
      logic [7:0]  d = 8'($urandom);
      case ($urandom % 6)
        0: begin wr_op(mk(8'h40, a, d)); pm[a][7:0] = d; end
        1: begin wr_op(mk(8'h48, a, d)); pm[a][15:8] = d; end
        2: begin wr_op(mk(8'hC0, {3'b0, a[7:0]}, d)); em[a[7:0]] = d; end
        3: rd_chk(mk(8'h20, a, 8'h00), pm[a][7:0], "R6 random low read");
        4: rd_chk(mk(8'h28, a, 8'h00), pm[a][15:8], "R6 R7 random high read");
        default: rd_chk(mk(8'hA0, {3'b0, a[7:0]}, 8'h00), em[a[7:0]], "R8 random eeprom read");
      endcase
    end

    // R11: lose framing, pulse reset with sck low, resync
    shift_bits(32'hFFF, 12, r);
    clocks(4);
    prog_rst_n = 1'b1;
    clocks(3);
    prog_rst_n = 1'b0;
    clocks(4);
    xfer(mk(8'hC0, 11'h007, 8'h22), r);
    c = mk(8'hA0, 11'h007, 8'h00);
    xfer(c, r);
    chk(r == exp_resp(c, 1'b0, 8'h00), "R11 enable cleared by pulse", r, exp_resp(c, 1'b0, 8'h00));
    xfer(32'hAC53_0000, r);
    chk(r == 32'h00AC_5300, "R11 echo after resync", r, 32'h00AC_5300);
    rd_chk(mk(8'hA0, 11'h007, 8'h00), em[8'h07], "R4 write before enable ignored");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule